// File: doc/BRIEF.md
# ATM Connection Lookup Engine

This block keeps a small table of 64-bit connection entries and resolves an incoming cell header against all of them in parallel. Each entry carries a 32-bit output word in its low half and its lookup key in its high half: a 16-bit channel identifier (VCI), a 12-bit path identifier (VPI) and four optional extension bits. One lookup finds either a channel hit, where VPI and VCI both agree, or a path hit, where the VPI agrees with an entry whose VCI field is all ones. The engine then returns the matched entry's output word and flags path hits.

Entries are added and removed through the same command port. The port takes one command per cycle: no-op, match, insert or delete. Insert and delete follow precedence rules that keep paths and channels consistent. A channel insert replaces a path entry that has the same VPI. A delete aimed at a channel that is absent removes the path entry that has the same VPI. A narrow-VPI mode restricts the VPI comparison to eight bits, and a per-bit enable brings the extension bits into the comparison.

Top module: `atm_conn_matcher`

## Requirements
- R1: After reset the table holds no entries and hit_o, vpc_o and word_o are all zero. A match issued straight after reset misses.
- R2: A match command (cmd_op_i=1) takes its key from cmd_data_i: VCI in bits 15:0, VPI in bits 27:16 and extension bits in 31:28. If a stored entry has an equal VCI (entry bits 47:32) and an equal VPI (entry bits 59:48), hit_o=1, vpc_o=0 and word_o carries entry bits 31:0. These outputs appear on the clock edge that captures the command.
- R3: When no channel hit exists, an entry whose VCI field is 0xFFFF and whose VPI equals the key's VPI produces hit_o=1 and vpc_o=1, with that entry's word, for any key VCI.
- R4: When a channel hit and a path hit both exist for a key, the channel entry wins and vpc_o=0.
- R5: With uni_mode_i=1, only VPI bits 7:0 take part in the comparison (entry bits 55:48 against key bits 23:16).
- R6: Entry bits 63:60 are compared with key bits 31:28 only at the positions where ext_cmp_i has a 1.
- R7: Bits 31:0 of an entry never take part in matching. An insert (cmd_op_i=2) whose key equals a stored entry's key overwrites that entry in place, and no second entry is added.
- R8: Inserting a channel entry (VCI other than 0xFFFF) whose VPI equals that of a stored path entry, with no exact key present, overwrites that path entry.
- R9: A delete (cmd_op_i=3) of a channel key that is not stored removes the stored path entry with the same VPI.
- R10: A delete of a stored key removes only that entry. A delete that matches neither a key nor a path leaves the table unchanged.
- R11: A new insert takes the lowest-numbered free slot. When all slots are full and no key or path rule applies, the insert is dropped.
- R12: When a match finds nothing, or when the cycle carries no match command, hit_o, vpc_o and word_o are zero.
- R13: No-op commands (cmd_op_i=0), match commands and cycles with cmd_valid_i=0 leave the table unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| uni_mode_i | input | 1 | Narrow 8-bit VPI comparison |
| ext_cmp_i | input | 4 | Per-bit compare enable for extension bits 63:60 |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 2 | 0 no-op, 1 match, 2 insert, 3 delete |
| cmd_data_i | input | 64 | Entry for insert or delete; key in bits 31:0 for match |
| hit_o | output | 1 | Match strobe |
| vpc_o | output | 1 | Hit came from a path entry |
| word_o | output | 32 | Output word of the matched entry |

## Verification
Every result of this block lands one register stage after the command. Match outputs appear on the same rising edge that captures the match command. An insert or delete changes the table on its capturing edge, so the very next command already sees the new contents. The bench drives each command on a falling edge and lets one rising edge pass. It reads hit_o, vpc_o and word_o on the following falling edge, and compares them with a reference table that it updates at that same rising edge. Every command is checked this way, including inserts, deletes and no-ops, whose expected outputs are zero.

// File: rtl/atm_cm_pkg.sv
package atm_cm_pkg;
  localparam int VCI_W     = 16;
  localparam int VPI_W     = 12;
  localparam int UNI_VPI_W = 8;
  localparam int EXT_W     = 4;
  localparam int WORD_W    = 32;
  localparam int KEY_W     = EXT_W + VPI_W + VCI_W;
  localparam int ENTRY_W   = KEY_W + WORD_W;

  typedef enum logic [1:0] {
    OP_NOP    = 2'd0,
    OP_MATCH  = 2'd1,
    OP_INSERT = 2'd2,
    OP_DELETE = 2'd3
  } op_e;

  // same layout for stored key (entry 63:32) and probe key (cmd 31:0)
  typedef struct packed {
    logic [EXT_W-1:0] ext;
    logic [VPI_W-1:0] vpi;
    logic [VCI_W-1:0] vci;
  } key_t;

  typedef struct packed {
    key_t              key;
    logic [WORD_W-1:0] word;
  } entry_t;
endpackage

// File: rtl/atm_cm_cmp.sv
module atm_cm_cmp
  import atm_cm_pkg::*;
(
  input  logic             valid_i,
  input  key_t             ent_i,
  input  key_t             probe_i,
  input  logic             uni_mode_i,
  input  logic [EXT_W-1:0] ext_cmp_i,
  output logic             exact_o,
  output logic             path_o,
  output logic             is_path_o
);
  logic vpi_eq, ext_eq, vci_eq;

  always_comb begin
    if (uni_mode_i) vpi_eq = (ent_i.vpi[UNI_VPI_W-1:0] == probe_i.vpi[UNI_VPI_W-1:0]);
    else            vpi_eq = (ent_i.vpi == probe_i.vpi);
  end

  assign ext_eq    = ~|((ent_i.ext ^ probe_i.ext) & ext_cmp_i);
  assign vci_eq    = (ent_i.vci == probe_i.vci);
  assign is_path_o = &ent_i.vci;
  assign exact_o   = valid_i & vpi_eq & ext_eq & vci_eq;
  assign path_o    = valid_i & vpi_eq & ext_eq & is_path_o;
endmodule

// File: rtl/atm_cm_first.sv
module atm_cm_first #(
  parameter int N     = 16,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end

  // R11 lowest requester is chosen
  always_comb begin
    if (found_o) begin
      lowest_pick_chk: assert (req_i[idx_o] && ((req_i & ((N'(1) << idx_o) - N'(1))) == '0));
    end
  end
endmodule

// File: rtl/atm_conn_matcher.sv
module atm_conn_matcher
  import atm_cm_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                uni_mode_i,
  input  logic [EXT_W-1:0]    ext_cmp_i,
  input  logic                cmd_valid_i,
  input  logic [1:0]          cmd_op_i,
  input  logic [ENTRY_W-1:0]  cmd_data_i,
  output logic                hit_o,
  output logic                vpc_o,
  output logic [WORD_W-1:0]   word_o
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  entry_t             ent_q [ENTRIES];
  logic [ENTRIES-1:0] val_q;

  op_e    op;
  entry_t cmd_ent;
  key_t   probe;
  logic   is_match, is_ins, is_del, new_is_path;

  assign op          = op_e'(cmd_op_i);
  assign cmd_ent     = entry_t'(cmd_data_i);
  assign is_match    = cmd_valid_i && (op == OP_MATCH);
  assign is_ins      = cmd_valid_i && (op == OP_INSERT);
  assign is_del      = cmd_valid_i && (op == OP_DELETE);
  assign probe       = (op == OP_MATCH) ? key_t'(cmd_data_i[KEY_W-1:0]) : cmd_ent.key;
  assign new_is_path = &cmd_ent.key.vci;

  logic [ENTRIES-1:0] exact_vec, path_vec, pathent_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    atm_cm_cmp u_cmp (
      .valid_i    (val_q[g]),
      .ent_i      (ent_q[g].key),
      .probe_i    (probe),
      .uni_mode_i (uni_mode_i),
      .ext_cmp_i  (ext_cmp_i),
      .exact_o    (exact_vec[g]),
      .path_o     (path_vec[g]),
      .is_path_o  (pathent_vec[g])
    );
  end

  logic             ex_f, pa_f, fr_f;
  logic [IDX_W-1:0] ex_idx, pa_idx, fr_idx;

  atm_cm_first #(.N(ENTRIES), .IDX_W(IDX_W)) u_first_exact (
    .req_i(exact_vec), .found_o(ex_f), .idx_o(ex_idx));
  atm_cm_first #(.N(ENTRIES), .IDX_W(IDX_W)) u_first_path (
    .req_i(path_vec), .found_o(pa_f), .idx_o(pa_idx));
  atm_cm_first #(.N(ENTRIES), .IDX_W(IDX_W)) u_first_free (
    .req_i(~val_q), .found_o(fr_f), .idx_o(fr_idx));

  // update decision
  logic             wr_en, clr_en;
  logic [IDX_W-1:0] wr_idx, clr_idx;

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = ex_idx;
    clr_en  = 1'b0;
    clr_idx = ex_idx;
    if (is_ins) begin
      if (ex_f) begin
        wr_en = 1'b1;
      end else if (!new_is_path && pa_f) begin
        wr_en  = 1'b1;
        wr_idx = pa_idx;
      end else if (fr_f) begin
        wr_en  = 1'b1;
        wr_idx = fr_idx;
      end
    end else if (is_del) begin
      if (ex_f) begin
        clr_en = 1'b1;
      end else if (pa_f) begin
        clr_en  = 1'b1;
        clr_idx = pa_idx;
      end
    end
  end

  // lookup result: channel hit beats path hit
  logic             hit_d, vpc_d;
  logic [WORD_W-1:0] word_d;
  logic [IDX_W-1:0] win_idx;

  always_comb begin
    win_idx = ex_f ? ex_idx : pa_idx;
    hit_d   = is_match && (ex_f || pa_f);
    vpc_d   = hit_d && pathent_vec[win_idx];
    word_d  = hit_d ? ent_q[win_idx].word : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q  <= '0;
      hit_o  <= 1'b0;
      vpc_o  <= 1'b0;
      word_o <= '0;
    end else begin
      hit_o  <= hit_d;
      vpc_o  <= vpc_d;
      word_o <= word_d;
      if (wr_en)  val_q[wr_idx]  <= 1'b1;
      if (clr_en) val_q[clr_idx] <= 1'b0;
    end
  end

  // entry contents carry no reset; validity gates them
  always_ff @(posedge clk_i) begin
    if (wr_en) ent_q[wr_idx] <= cmd_ent;
  end

  // R3
  vpc_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vpc_o |-> hit_o);

  // R12
  hit_after_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $past(cmd_valid_i && (cmd_op_i == OP_MATCH)));

  // R11
  ins_no_shrink_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ins |=> ($countones(val_q) >= $past($countones(val_q))));

  // R10
  del_one_at_most_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_del |=> (($countones(val_q) + 1 >= $past($countones(val_q)))
               && ($countones(val_q) <= $past($countones(val_q)))));

  // R13
  table_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(is_ins || is_del) |=> $stable(val_q));
endmodule

// File: tb/atm_conn_matcher_tb.sv
module atm_conn_matcher_tb;
  localparam int ENTRIES = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        uni = 1'b0;
  logic [3:0]  ecmp = 4'h0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [63:0] cmd_data = '0;
  logic        hit, vpc;
  logic [31:0] word;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic        m_val [ENTRIES];
  logic [63:0] m_ent [ENTRIES];

  always #2 clk = ~clk;

  atm_conn_matcher #(.ENTRIES(ENTRIES)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .uni_mode_i(uni), .ext_cmp_i(ecmp),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_data_i(cmd_data),
    .hit_o(hit), .vpc_o(vpc), .word_o(word));

  function automatic logic [63:0] mk(logic [3:0] e, logic [11:0] p, logic [15:0] c, logic [31:0] w);
    return {e, p, c, w};
  endfunction

  function automatic logic [63:0] pk(logic [3:0] e, logic [11:0] p, logic [15:0] c);
    return {32'h0, e, p, c};
  endfunction

  function automatic bit m_vx(logic [31:0] e, logic [31:0] k);
    bit v;
    v = uni ? (e[23:16] == k[23:16]) : (e[27:16] == k[27:16]);
    return v && (((e[31:28] ^ k[31:28]) & ecmp) == 4'h0);
  endfunction

  function automatic bit m_keq(logic [31:0] e, logic [31:0] k);
    return m_vx(e, k) && (e[15:0] == k[15:0]);
  endfunction

  function automatic bit m_peq(logic [31:0] e, logic [31:0] k);
    return m_vx(e, k) && (e[15:0] == 16'hFFFF);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act hit/vpc/word=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic m_clear();
    for (int i = 0; i < ENTRIES; i++) begin
      m_val[i] = 1'b0;
      m_ent[i] = '0;
    end
  endtask

  task automatic do_reset(input string req);
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    m_clear();
    repeat (3) @(negedge clk);
    chk({hit, vpc, word} == 34'h0, req, {hit, vpc, word}, 34'h0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // drive at negedge, capture at posedge, check at next negedge
  task automatic do_op(input logic [1:0] op, input logic [63:0] d, input string req);
    logic [31:0] k, ew;
    logic eh, ev;
    int ex, pa, fr;
    k  = (op == 2'd1) ? d[31:0] : d[63:32];
    ex = -1; pa = -1; fr = -1;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (m_val[i] && m_keq(m_ent[i][63:32], k)) ex = i;
      if (m_val[i] && m_peq(m_ent[i][63:32], k)) pa = i;
      if (!m_val[i]) fr = i;
    end
    eh = 1'b0; ev = 1'b0; ew = '0;
    if (op == 2'd1) begin
      if (ex >= 0) begin
        eh = 1'b1; ev = &m_ent[ex][47:32]; ew = m_ent[ex][31:0];
      end else if (pa >= 0) begin
        eh = 1'b1; ev = 1'b1; ew = m_ent[pa][31:0];
      end
    end
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_data  = d;
    @(posedge clk);
    if (op == 2'd2) begin
      if (ex >= 0) m_ent[ex] = d;
      else if (!(&d[47:32]) && pa >= 0) m_ent[pa] = d;
      else if (fr >= 0) begin
        m_ent[fr] = d; m_val[fr] = 1'b1;
      end
    end else if (op == 2'd3) begin
      if (ex >= 0) m_val[ex] = 1'b0;
      else if (pa >= 0) m_val[pa] = 1'b0;
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    chk({hit, vpc, word} == {eh, ev, ew}, req, {hit, vpc, word}, {eh, ev, ew});
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_clear();
    @(negedge clk);
    do_reset("R1 reset outputs");
    do_op(2'd1, pk(4'h0, 12'h123, 16'h0040), "R1 match on empty table");

    // channel
    do_op(2'd2, mk(4'h0, 12'h123, 16'h0040, 32'hAAAA_0001), "R13 insert quiet");
    do_op(2'd1, pk(4'h0, 12'h123, 16'h0040), "R2 channel hit");
    do_op(2'd1, pk(4'h0, 12'h123, 16'h0041), "R12 miss other vci");
    do_op(2'd0, pk(4'h0, 12'h123, 16'h0040), "R12 nop no strobe");
    // path
    do_op(2'd2, mk(4'h0, 12'h055, 16'hFFFF, 32'hBBBB_0002), "R13 insert path");
    do_op(2'd1, pk(4'h0, 12'h055, 16'h0777), "R3 path hit");
    // channel + path on same VPI
    do_op(2'd2, mk(4'h0, 12'h200, 16'h0005, 32'hCCCC_0003), "R13 insert ch");
    do_op(2'd2, mk(4'h0, 12'h200, 16'hFFFF, 32'hCCCC_0004), "R13 insert path");
    do_op(2'd1, pk(4'h0, 12'h200, 16'h0005), "R4 channel beats path");
    do_op(2'd1, pk(4'h0, 12'h200, 16'h0006), "R3 path fallback");
    // channel overwrites path
    do_op(2'd2, mk(4'h0, 12'h055, 16'h0010, 32'hDDDD_0005), "R13 insert ch");
    do_op(2'd1, pk(4'h0, 12'h055, 16'h0777), "R8 path replaced");
    do_op(2'd1, pk(4'h0, 12'h055, 16'h0010), "R8 channel present");
    // delete fallback
    do_op(2'd2, mk(4'h0, 12'h300, 16'hFFFF, 32'hEEEE_0006), "R13 insert path");
    do_op(2'd3, mk(4'h0, 12'h300, 16'h0009, 32'h0), "R13 delete quiet");
    do_op(2'd1, pk(4'h0, 12'h300, 16'h0001), "R9 path removed");
    // delete exact and absent
    do_op(2'd3, mk(4'h0, 12'h123, 16'h0040, 32'h0), "R13 delete quiet");
    do_op(2'd1, pk(4'h0, 12'h123, 16'h0040), "R10 deleted misses");
    do_op(2'd3, mk(4'h0, 12'h3FF, 16'h0001, 32'h0), "R13 delete quiet");
    do_op(2'd1, pk(4'h0, 12'h055, 16'h0010), "R10 absent delete no effect");
    // low bits not part of key
    do_op(2'd2, mk(4'h0, 12'h055, 16'h0010, 32'h1234_5678), "R13 insert");
    do_op(2'd1, pk(4'h0, 12'h055, 16'h0010), "R7 overwrite in place");
    do_op(2'd3, mk(4'h0, 12'h055, 16'h0010, 32'h0), "R13 delete");
    do_op(2'd1, pk(4'h0, 12'h055, 16'h0010), "R7 no duplicate left");
    do_op(2'd2, mk(4'h0, 12'h055, 16'h0010, 32'h0000_5555), "R13 insert");
    // narrow VPI
    uni = 1'b1;
    do_op(2'd1, pk(4'h0, 12'hA55, 16'h0010), "R5 uni upper bits ignored");
    uni = 1'b0;
    do_op(2'd1, pk(4'h0, 12'hA55, 16'h0010), "R5 full vpi compare");
    // extension bits
    do_op(2'd2, mk(4'hA, 12'h0AA, 16'h0020, 32'h6666_0007), "R13 insert ext");
    do_op(2'd1, pk(4'h0, 12'h0AA, 16'h0020), "R6 ext disabled");
    ecmp = 4'b0010;
    do_op(2'd1, pk(4'h0, 12'h0AA, 16'h0020), "R6 ext bit1 mismatch");
    do_op(2'd1, pk(4'h2, 12'h0AA, 16'h0020), "R6 ext bit1 match");
    ecmp = 4'h0;

    // capacity
    do_reset("R1 reset outputs again");
    for (int i = 0; i < ENTRIES; i++)
      do_op(2'd2, mk(4'h0, 12'(i), 16'(16'h100 + i), 32'(32'hF000 + i)), "R11 fill");
    do_op(2'd2, mk(4'h0, 12'h050, 16'h0150, 32'h0000_F0FF), "R11 insert when full");
    do_op(2'd1, pk(4'h0, 12'h050, 16'h0150), "R11 full insert dropped");
    for (int i = 0; i < ENTRIES; i++)
      do_op(2'd1, pk(4'h0, 12'(i), 16'(16'h100 + i)), "R11 all stored");
    do_op(2'd3, mk(4'h0, 12'h003, 16'h0103, 32'h0), "R10 delete slot 3");
    do_op(2'd2, mk(4'h0, 12'h050, 16'h0150, 32'h0000_F0FF), "R11 reuse free slot");
    do_op(2'd1, pk(4'h0, 12'h050, 16'h0150), "R11 reused slot hits");
    do_op(2'd1, pk(4'h0, 12'h003, 16'h0103), "R10 slot 3 gone");

    // constrained random against the reference table
    do_reset("R1 reset before random");
    void'($urandom(32'd20240611));
    ecmp = 4'b1001;
    for (int n = 0; n < 600; n++) begin
      logic [1:0]  op;
      logic [11:0] p;
      logic [15:0] c;
      logic [3:0]  e;
      op = 2'($urandom_range(0, 3));
      p  = 12'($urandom_range(0, 7));
      case ($urandom_range(0, 4))
        0: c = 16'h0001;
        1: c = 16'h0002;
        2: c = 16'h0003;
        default: c = 16'hFFFF;
      endcase
      e = 4'($urandom_range(0, 3)) << 2 | 4'($urandom_range(0, 1));
      if (op == 2'd1) do_op(op, {32'($urandom), e, p, c}, "R13 random lookup");
      else            do_op(op, mk(e, p, c, 32'($urandom)), "R13 random update");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule